// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block holds the interrupt state for one group of up to 32 sources. Every source owns the same bit index in every register of the bank. Hardware event pulses set cause bits. Software reads and writes the bank through a simple 32-bit register port addressed by word offset. A single registered level output tells the host that at least one unmasked cause is pending.

Each source has its own clear-mode bit. When the bit is 0, its cause is cleared by writing 1. When the bit is 1, the cause clears itself when a read returns it. The same rule applies through the raw cause view and through the masked cause view. Software can raise any cause by writing the set register. It can change the mask by a direct write, or set and clear single mask bits through two aliases that ignore zeros.

The port is combinational on the read side. `regRdata` shows the addressed register in the cycle `regRd` is high, and any clear-on-read takes effect at the clock edge that ends that cycle.

Top module: `irq_bank`

## Requirements
- R1: After reset, every cause bit is 0, every clear-mode bit is 0 (write-one-to-clear), every mask bit is 1, and `irqOut` is 0.
- R2: Word offsets decode as follows: 0 is clear-mode (read/write), 1 is raw cause, 2 is masked cause, 3 is cause set, 4 is mask, 5 is mask set, and 6 is mask clear. A read of the clear-mode register returns the last value written to it.
- R3: Writing offset 1 or offset 2 clears each cause bit that has a 1 in the write data and a 0 clear-mode bit. The write ignores data bits that are 0 and data bits whose clear-mode bit is 1.
- R4: A read of offset 1 returns the raw cause and clears, at the next edge, every returned 1 whose clear-mode bit is 1. Bits whose clear-mode bit is 0 are not changed by any read.
- R5: A read of offset 2 returns cause AND NOT mask. At the next edge it clears only those returned 1 bits whose clear-mode bit is 1, so masked causes survive the read.
- R6: Writing 1 to a bit at offset 3 sets that cause bit at the next edge.
- R7: A write to offset 4 replaces the whole mask. Writing 1 at offset 5 sets the corresponding mask bits and writing 1 at offset 6 clears them, with zeros leaving bits unchanged.
- R8: A hardware event pulse on a bit sets that cause bit at the next edge. If the event coincides with a write-one-to-clear or a clear-on-read of the same bit, the bit stays set.
- R9: After every clock edge, `irqOut` is 1 exactly when some cause bit is set whose mask bit is 0.
- R10: Reads of offsets 3, 5, 6 and 7 return 0 and change no state. A write to offset 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwEvt | input | SRC_N | One-cycle hardware event pulses, one per source |
| regAddr | input | 3 | Word offset of the accessed register |
| regWr | input | 1 | Write strobe for this cycle |
| regRd | input | 1 | Read strobe for this cycle |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid while regRd is high, otherwise 0 |
| irqOut | output | 1 | Registered level interrupt to the host |

## Verification
The bound checker watches several properties on every cycle. It checks that an event always lands in the cause register even against a simultaneous clear. It checks that the set register and the mask-set alias take effect on the next edge, that a clear-on-read empties the bits it returned, that the alias offsets read as zero, and that `irqOut` follows the unmasked cause. Some behaviour can only be shown by the bench's scenarios driving a reference model: the per-bit mix of write-one-to-clear and clear-on-read bits, the fact that a masked-view read leaves masked bits pending, the ignored writes to clear-on-read bits, and the absence of side effects on alias reads. The bench checks these through the values read back over the register port.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int REG_W = 32;
  localparam int OFF_W = 3;

  typedef enum logic [OFF_W-1:0] {
    OFF_MODE   = 3'd0,
    OFF_CAUSE  = 3'd1,
    OFF_MASKED = 3'd2,
    OFF_SET    = 3'd3,
    OFF_MASK   = 3'd4,
    OFF_MSET   = 3'd5,
    OFF_MCLR   = 3'd6,
    OFF_RSVD   = 3'd7
  } regOff_e;

  typedef struct packed {
    logic    wrMode;
    logic    wrCause;
    logic    wrMasked;
    logic    wrSet;
    logic    wrMask;
    logic    wrMaskSet;
    logic    wrMaskClr;
    logic    rdCause;
    logic    rdMasked;
    logic    rdEn;
    regOff_e rdOff;
  } strobe_t;
endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
(
  input  logic [OFF_W-1:0] regAddr,
  input  logic             regWr,
  input  logic             regRd,
  output strobe_t          strb
);
  regOff_e off;

  always_comb begin
    off = regOff_e'(regAddr);
    strb = '0;
    strb.rdEn  = regRd;
    strb.rdOff = off;
    if (regWr) begin
      unique case (off)
        OFF_MODE:   strb.wrMode    = 1'b1;
        OFF_CAUSE:  strb.wrCause   = 1'b1;
        OFF_MASKED: strb.wrMasked  = 1'b1;
        OFF_SET:    strb.wrSet     = 1'b1;
        OFF_MASK:   strb.wrMask    = 1'b1;
        OFF_MSET:   strb.wrMaskSet = 1'b1;
        OFF_MCLR:   strb.wrMaskClr = 1'b1;
        default:    ;
      endcase
    end
    if (regRd) begin
      strb.rdCause  = (off == OFF_CAUSE);
      strb.rdMasked = (off == OFF_MASKED);
    end
  end
endmodule

// File: rtl/irq_bank_cell.sv
// One source: its cause bit with write-one-to-clear or clear-on-read
// behaviour chosen by modeBit. A set request always wins over a clear.
module irq_bank_cell (
  input  logic clk,
  input  logic rstN,
  input  logic modeBit,
  input  logic w1cReq,
  input  logic rdReq,
  input  logic swSet,
  input  logic hwSet,
  output logic causeBit,
  output logic causeNext
);
  logic clrHit;

  always_comb begin
    clrHit    = (w1cReq & ~modeBit) | (rdReq & modeBit);
    causeNext = (causeBit & ~clrHit) | swSet | hwSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) causeBit <= 1'b0;
    else       causeBit <= causeNext;
  end
endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int SRC_N = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [REG_W-1:0] regWdata,
  input  logic [SRC_N-1:0] hwEvt,
  output logic [REG_W-1:0] regRdata,
  output logic [SRC_N-1:0] causeQ,
  output logic [SRC_N-1:0] maskQ,
  output logic [SRC_N-1:0] modeQ,
  output logic             irqQ
);
  logic [SRC_N-1:0] wData;
  logic [SRC_N-1:0] w1cVec;
  logic [SRC_N-1:0] rdClrVec;
  logic [SRC_N-1:0] setVec;
  logic [SRC_N-1:0] causeNext;
  logic [SRC_N-1:0] maskNext;
  logic [SRC_N-1:0] maskedView;

  function automatic logic [REG_W-1:0] widen(input logic [SRC_N-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    r[SRC_N-1:0] = v;
    return r;
  endfunction

  always_comb begin
    wData      = regWdata[SRC_N-1:0];
    maskedView = causeQ & ~maskQ;
    w1cVec     = (strb.wrCause | strb.wrMasked) ? wData : '0;
    setVec     = strb.wrSet ? wData : '0;
    if (strb.rdCause)       rdClrVec = causeQ;
    else if (strb.rdMasked) rdClrVec = maskedView;
    else                    rdClrVec = '0;
  end

  for (genvar b = 0; b < SRC_N; b++) begin : g_cell
    irq_bank_cell u_cell (
      .clk      (clk),
      .rstN     (rstN),
      .modeBit  (modeQ[b]),
      .w1cReq   (w1cVec[b]),
      .rdReq    (rdClrVec[b]),
      .swSet    (setVec[b]),
      .hwSet    (hwEvt[b]),
      .causeBit (causeQ[b]),
      .causeNext(causeNext[b])
    );
  end

  always_comb begin
    maskNext = maskQ;
    if (strb.wrMask)    maskNext = wData;
    if (strb.wrMaskSet) maskNext = maskQ | wData;
    if (strb.wrMaskClr) maskNext = maskQ & ~wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      maskQ <= '1;
      irqQ  <= 1'b0;
    end else begin
      if (strb.wrMode) modeQ <= wData;
      maskQ <= maskNext;
      irqQ  <= |(causeNext & ~maskNext);
    end
  end

  always_comb begin
    regRdata = '0;
    if (strb.rdEn) begin
      unique case (strb.rdOff)
        OFF_MODE:   regRdata = widen(modeQ);
        OFF_CAUSE:  regRdata = widen(causeQ);
        OFF_MASKED: regRdata = widen(maskedView);
        OFF_MASK:   regRdata = widen(maskQ);
        default:    regRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int SRC_N = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] hwEvt,
  input  logic [2:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  output logic             irqOut
);
  strobe_t          strb;
  logic [SRC_N-1:0] causeVec;
  logic [SRC_N-1:0] maskVec;
  logic [SRC_N-1:0] modeVec;

  irq_bank_ctrl u_ctrl (
    .regAddr(regAddr),
    .regWr  (regWr),
    .regRd  (regRd),
    .strb   (strb)
  );

  irq_bank_dp #(.SRC_N(SRC_N)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regWdata(regWdata),
    .hwEvt   (hwEvt),
    .regRdata(regRdata),
    .causeQ  (causeVec),
    .maskQ   (maskVec),
    .modeQ   (modeVec),
    .irqQ    (irqOut)
  );
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int SRC_N = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [SRC_N-1:0] hwEvt,
  input logic [2:0]       regAddr,
  input logic             regWr,
  input logic             regRd,
  input logic [31:0]      regWdata,
  input logic [31:0]      regRdata,
  input logic             irqOut,
  input logic [SRC_N-1:0] causeVec,
  input logic [SRC_N-1:0] maskVec,
  input logic [SRC_N-1:0] modeVec
);
  // R8
  evt_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|hwEvt) |=> ((causeVec & $past(hwEvt)) == $past(hwEvt)));

  // R6
  sw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd3) |=>
      ((causeVec & $past(regWdata[SRC_N-1:0])) == $past(regWdata[SRC_N-1:0])));

  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd5) |=>
      ((maskVec & $past(regWdata[SRC_N-1:0])) == $past(regWdata[SRC_N-1:0])));

  // R4
  cor_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 3'd1 && !regWr && hwEvt == '0) |=>
      ((causeVec & $past(causeVec & modeVec)) == '0));

  // R10
  alias_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && (regAddr == 3'd3 || regAddr == 3'd5 || regAddr == 3'd6 || regAddr == 3'd7))
      |-> (regRdata == 32'd0));

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|(causeVec & ~maskVec)));
endmodule

bind irq_bank irq_bank_chk #(.SRC_N(SRC_N)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .hwEvt   (hwEvt),
  .regAddr (regAddr),
  .regWr   (regWr),
  .regRd   (regRd),
  .regWdata(regWdata),
  .regRdata(regRdata),
  .irqOut  (irqOut),
  .causeVec(causeVec),
  .maskVec (maskVec),
  .modeVec (modeVec)
);

// File: tb/irq_bank_tb.sv
module irq_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] hwEvt = '0;
  logic [2:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mCause = '0;
  logic [31:0] mMode  = '0;
  logic [31:0] mMask  = '1;

  always #5 clk = ~clk;

  irq_bank u_dut (
    .clk(clk), .rstN(rstN), .hwEvt(hwEvt), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mMode;
      3'd1: return mCause;
      3'd2: return mCause & ~mMask;
      3'd4: return mMask;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] nextCause(input logic wr, input logic rd,
      input logic [2:0] a, input logic [31:0] d, input logic [31:0] ev);
    logic [31:0] c;
    c = mCause;
    if (wr && (a == 3'd1 || a == 3'd2)) c = c & ~(d & ~mMode);
    if (rd && a == 3'd1) c = c & ~(mCause & mMode);
    if (rd && a == 3'd2) c = c & ~(mCause & ~mMask & mMode);
    if (wr && a == 3'd3) c = c | d;
    return c | ev;
  endfunction

  function automatic logic [31:0] nextMask(input logic wr, input logic [2:0] a,
      input logic [31:0] d);
    if (!wr) return mMask;
    case (a)
      3'd4: return d;
      3'd5: return mMask | d;
      3'd6: return mMask & ~d;
      default: return mMask;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic rd, input logic [2:0] a,
      input logic [31:0] d, input logic [31:0] ev, input string req);
    logic [31:0] nc;
    logic [31:0] nm;
    @(negedge clk);
    regWr = wr; regRd = rd; regAddr = a; regWdata = d; hwEvt = ev;
    #1;
    if (rd) check(req, regRdata, expRead(a));
    nc = nextCause(wr, rd, a, d, ev);
    nm = nextMask(wr, a, d);
    @(posedge clk);
    #1;
    mCause = nc;
    mMask  = nm;
    if (wr && a == 3'd0) mMode = d;
    regWr = 1'b0; regRd = 1'b0; hwEvt = '0;
    check("R9 irq", {31'd0, irqOut}, {31'd0, |(mCause & ~mMask)});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 irq", {31'd0, irqOut}, 32'd0);
    step(0, 1, 3'd0, 0, 0, "R1 mode");
    step(0, 1, 3'd1, 0, 0, "R1 cause");
    step(0, 1, 3'd4, 0, 0, "R1 mask");
    // R8 event sets cause; R7 clear alias unmasks
    step(0, 0, 3'd0, 0, 32'h0000_0008, "R8 evt");
    step(1, 0, 3'd6, 32'h0000_0008, 0, "R7 mclr");
    step(0, 1, 3'd2, 0, 0, "R5 masked");
    step(0, 1, 3'd1, 0, 0, "R4 w1c bit unaffected by read");
    // R3 write-one-to-clear
    step(1, 0, 3'd1, 32'h0000_0008, 0, "R3 w1c");
    step(0, 1, 3'd1, 0, 0, "R3 after w1c");
    // R2 mode readback, R6 software set, R4 clear on read
    step(1, 0, 3'd0, 32'h0000_0030, 0, "R2 mode wr");
    step(0, 1, 3'd0, 0, 0, "R2 mode rd");
    step(1, 0, 3'd3, 32'h0000_0031, 0, "R6 set");
    step(1, 0, 3'd1, 32'h0000_0030, 0, "R3 ignored on cor bits");
    step(0, 1, 3'd1, 0, 0, "R4 cor read");
    step(0, 1, 3'd1, 0, 0, "R4 after cor");
    // R5 masked view read leaves masked bits pending
    step(1, 0, 3'd3, 32'h0000_0030, 0, "R6 set");
    step(1, 0, 3'd6, 32'h0000_0010, 0, "R7 mclr");
    step(0, 1, 3'd2, 0, 0, "R5 masked cor");
    step(0, 1, 3'd1, 0, 0, "R5 masked bit kept");
    // R8 event against clear in same cycle
    step(0, 1, 3'd1, 0, 32'h0000_0020, "R8 evt vs cor");
    step(0, 1, 3'd1, 0, 0, "R8 kept after cor");
    step(1, 0, 3'd1, 32'h0000_0001, 32'h0000_0001, "R8 evt vs w1c");
    step(0, 1, 3'd1, 0, 0, "R8 kept after w1c");
    // R10 alias reads zero, no effect
    step(0, 1, 3'd3, 0, 0, "R10 set rd");
    step(0, 1, 3'd5, 0, 0, "R10 mset rd");
    step(0, 1, 3'd6, 0, 0, "R10 mclr rd");
    step(1, 0, 3'd7, 32'hFFFF_FFFF, 0, "R10 rsvd wr");
    step(0, 1, 3'd7, 0, 0, "R10 rsvd rd");
    step(0, 1, 3'd4, 0, 0, "R10 mask unchanged");
    step(0, 1, 3'd1, 0, 0, "R10 cause unchanged");
    // R7 direct write and set alias
    step(1, 0, 3'd4, 32'h0F0F_0F0F, 0, "R7 mask wr");
    step(1, 0, 3'd5, 32'h3000_0000, 0, "R7 mset");
    step(0, 1, 3'd4, 0, 0, "R7 mask rd");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  a;
      logic [31:0] d;
      logic [31:0] ev;
      int          op;
      a  = 3'($urandom % 8);
      op = int'($urandom % 4);
      d  = ($urandom % 2 == 0) ? ($urandom & $urandom) : $urandom;
      ev = ($urandom % 3 == 0) ? ($urandom & $urandom & $urandom) : 32'd0;
      if (op == 0)      step(0, 0, a, 0, ev, "R8 random evt");
      else if (op == 1) step(0, 1, a, 0, ev, "R2 R4 R5 random rd");
      else              step(1, 0, a, d, ev, "R3 R6 R7 random wr");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule